// File: doc/BRIEF.md
# Protected Interrupt Vector Relocation Register

This block is a byte-wide control register that decides where the interrupt vector table lives. The table sits either at address zero of program memory or at the base of the boot-loader region, and that base arrives on an input. The same register also holds three external-interrupt enable bits.

Software cannot flip the table location with a single store. It must first arm a short change window by setting a change-enable bit. It must then write the new location while that window is still open. From the cycle the window is armed, the block raises an interrupt-suppress output. This output is separate from the CPU's global enable flag and never changes that flag.

The block also applies the boot-lock rules. When the table and the running code sit in different sections and the lock for that case is set, interrupts are held off.

Top module: `vec_reloc_reg`

## Requirements
- R1: After reset, `rd_data` is 0x00, `vec_base` is 0 and `irq_suppress` is 0 when both lock inputs are 0.
- R2: `vec_base` is 0 while the select bit (read bit 1) is 0. It equals `boot_base` while that bit is 1.
- R3: A write with bit 0 = 0 outside an open window stores bits 7..5 as the interrupt enables and leaves the select bit unchanged.
- R4: Writing bit 0 = 1 opens a window. Read bit 0 is 1 for exactly 4 cycles after that write and then returns to 0. A select write after expiry has no effect on the select bit.
- R5: A write with bit 0 = 0 inside the window loads bit 1 into the select bit and clears read bit 0 in the next cycle.
- R6: `irq_suppress` is 1 in the cycle of a write with bit 0 = 1 and for as long as the window stays open. It falls with the window when no select write happens.
- R7: After a select write, `irq_suppress` stays 1 until the second `retire` pulse that comes after the write cycle. It is 0 from the following cycle.
- R8: Writing bit 0 = 1 while a window is open restarts the full 4-cycle window.
- R9: With select = 1, `lock_app_irq` = 1 and `in_boot` = 0, `irq_suppress` is 1.
- R10: With select = 0, `lock_boot_irq` = 1 and `in_boot` = 1, `irq_suppress` is 1. The mixed cases of R9 and R10 do not suppress.
- R11: Read bits 4..2 are always 0, whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| retire | input | 1 | One pulse per completed instruction |
| boot_base | input | AW | Base address of the boot-loader region |
| in_boot | input | 1 | 1 while code runs from the boot section |
| lock_app_irq | input | 1 | Lock: block interrupts in the application section when vectors are in boot |
| lock_boot_irq | input | 1 | Lock: block interrupts in the boot section when vectors are in the application |
| vec_base | output | AW | Current vector table base |
| irq_suppress | output | 1 | Interrupt mask to the interrupt controller |

## Verification
Two cases are hard to reach from the ports.

The first is the exact last cycle of the change window. It is reached by arming the window from a known negative edge and then sampling read bit 0 on each of the following cycles. The same counting is repeated with a second arm write in the middle of the window, to show that the window restarts.

The second is the release of suppression after a select write. It depends on `retire` pulses that come after the write cycle. The stimulus therefore issues single, separated retire pulses and checks the mask after each one.

// File: rtl/vec_reloc_reg.sv
module vec_reloc_reg #(
  parameter int AW     = 16,
  parameter int WIN    = 4,
  parameter int HOLD_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  input  logic          retire,
  input  logic [AW-1:0] boot_base,
  input  logic          in_boot,
  input  logic          lock_app_irq,
  input  logic          lock_boot_irq,
  output logic [AW-1:0] vec_base,
  output logic          irq_suppress
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int HW = $clog2(HOLD_N + 1);

  logic [2:0]    int_en;
  logic          sel, ce;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hold;

  wire arm     = wr_en & wr_data[0];
  wire sel_wr  = wr_en & ~wr_data[0] & ce;
  wire lock_hit = (sel & lock_app_irq & ~in_boot) | (~sel & lock_boot_irq & in_boot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_en <= '0;
      sel    <= 1'b0;
      ce     <= 1'b0;
      cnt    <= '0;
      hold   <= '0;
    end else begin
      if (wr_en) int_en <= wr_data[7:5];
      if (arm) begin
        ce  <= 1'b1;
        cnt <= CW'(WIN - 1);
      end else if (sel_wr) begin
        ce  <= 1'b0;
        sel <= wr_data[1];
      end else if (ce) begin
        if (cnt == '0) ce <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end
      if (sel_wr)                 hold <= HW'(HOLD_N);
      else if (retire && hold != '0) hold <= hold - 1'b1;
    end
  end

  assign rd_data      = {int_en, 3'b000, sel, ce};
  assign vec_base     = sel ? boot_base : '0;
  assign irq_suppress = arm | ce | (hold != '0) | lock_hit;

  p_sel_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel) |-> $past(ce && wr_en && !wr_data[0]));

  p_ce_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce) |-> $past(wr_en && wr_data[0]));

  p_ce_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && wr_en && !wr_data[0]) |=> !rd_data[0]);

  p_mask_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |-> irq_suppress);

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && wr_en && !wr_data[0]) |=> irq_suppress);

  p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> rd_data[4:2] == 3'b000);
endmodule

// File: tb/vec_reloc_reg_tb.sv
module vec_reloc_reg_tb_top;
  localparam int AW = 16;
  localparam logic [AW-1:0] BOOT = 16'h3C00;

  logic clk = 0, rst_n = 0, wr_en = 0, retire = 0;
  logic in_boot = 0, lock_app_irq = 0, lock_boot_irq = 0;
  logic [7:0] wr_data = '0, rd_data;
  logic [AW-1:0] vec_base;
  logic irq_suppress;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  vec_reloc_reg #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .retire(retire), .boot_base(BOOT), .in_boot(in_boot),
    .lock_app_irq(lock_app_irq), .lock_boot_irq(lock_boot_irq),
    .vec_base(vec_base), .irq_suppress(irq_suppress));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic ret_pulse();
    retire = 1;
    @(negedge clk);
    retire = 0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 vec_base", vec_base, 0);
    chk("R1 irq_suppress", irq_suppress, 0);
  endtask

  task automatic t_plain();
    wr(8'hFE);
    chk("R3 int bits", rd_data[7:5], 3'b111);
    chk("R3 select kept", rd_data[1], 0);
    chk("R11 reserved", rd_data[4:2], 0);
    chk("R2 base app", vec_base, 0);
  endtask

  task automatic t_unlock();
    wr_en = 1; wr_data = 8'h01;
    #1 chk("R6 mask in arm cycle", irq_suppress, 1);
    @(negedge clk);
    wr_en = 0; wr_data = '0;
    chk("R4 ce set", rd_data[0], 1);
    wr(8'h02);
    chk("R5 select loaded", rd_data[1], 1);
    chk("R5 ce cleared", rd_data[0], 0);
    chk("R2 base boot", vec_base, BOOT);
    chk("R7 mask after write", irq_suppress, 1);
    ret_pulse();
    chk("R7 mask after 1 retire", irq_suppress, 1);
    ret_pulse();
    chk("R7 mask after 2 retires", irq_suppress, 0);
  endtask

  task automatic t_expire();
    wr(8'h01);
    chk("R4 ce cycle 1", rd_data[0], 1);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      chk("R4 ce held", rd_data[0], 1);
      chk("R6 mask held", irq_suppress, 1);
    end
    @(negedge clk);
    chk("R4 ce expired", rd_data[0], 0);
    chk("R6 mask released", irq_suppress, 0);
    wr(8'h00);
    chk("R4 late select ignored", rd_data[1], 1);
    chk("R4 base stays boot", vec_base, BOOT);
  endtask

  task automatic t_restart();
    wr(8'h01);
    @(negedge clk);
    @(negedge clk);
    wr(8'h01);
    for (int k = 1; k <= 4; k++) begin
      chk("R8 window restarted", rd_data[0], 1);
      @(negedge clk);
    end
    chk("R8 window closes", rd_data[0], 0);
  endtask

  task automatic t_locks();
    lock_app_irq = 1; in_boot = 0;
    #1 chk("R9 app lock", irq_suppress, 1);
    in_boot = 1;
    #1 chk("R9 boot exec no lock", irq_suppress, 0);
    lock_app_irq = 0; lock_boot_irq = 1;
    #1 chk("R10 mixed case", irq_suppress, 0);
    lock_boot_irq = 0; in_boot = 0;
    @(negedge clk);
    wr(8'h01);
    wr(8'h00);
    ret_pulse();
    ret_pulse();
    chk("R2 back to app", vec_base, 0);
    lock_boot_irq = 1; in_boot = 1;
    #1 chk("R10 boot lock", irq_suppress, 1);
    in_boot = 0;
    #1 chk("R10 app exec no lock", irq_suppress, 0);
    lock_boot_irq = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_unlock();
    t_expire();
    t_restart();
    t_locks();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule